// File: doc/BRIEF.md
# Grayscale PWM Generator with Synchronized Blank Release

This block turns a bank of sixteen latched grayscale words into sixteen LED on/off enables. A grayscale clock, sampled in the system clock domain, drives a shared brightness counter. Each channel is lit from the start of a display cycle and goes dark once the counter reaches that channel's word. A channel whose word is zero never lights.

A blank input darkens every channel at once. When blank is released, the block does not restart right away. It first waits for the next rising edge of the grayscale clock and then for the falling edge after it. On that falling edge the counter restarts at zero and the channels light. The counter stops at full scale and holds there until the next blank pulse. Full scale is 255 in narrow (8-bit) mode and 65535 in wide (16-bit) mode.

A brightness setting can slow the count by dividing the grayscale clock. Registered copies of the blank and grayscale clock inputs are passed on so that a downstream stage can be cascaded.

Top module: `gspwm_top`

## Requirements
- R1: While reset is asserted and just after it, every bit of `led_on` is 0, and `blank_dly` and `gs_clk_dly` are both 0.
- R2: In any cycle where `blank` is 1, every bit of `led_on` is 0 in that same cycle, without waiting for a clock edge.
- R3: After `blank` falls, `led_on` stays all 0 through the next rising edge of `gs_clk`. The channels light at the first system clock edge that samples `gs_clk` low after that rise.
- R4: At release the brightness count is 0. It increments once per divided tick, and a tick is taken on sampled rising edges of `gs_clk`. Channel i is lit exactly while count < its effective word.
- R5: A channel whose effective word is 0 is never lit.
- R6: With `wide_mode` = 0, only bits [7:0] of each channel word are used, and the count saturates at 255 until the next blank.
- R7: With `wide_mode` = 1, all 16 bits of each channel word are used, and the count saturates at 65535.
- R8: With `bright_en` = 0, each `gs_clk` rising edge is one tick (divide by 1), whatever the value of `bright_code`.
- R9: With `bright_en` = 1, one tick occurs every (32 − `bright_code`) rising edges of `gs_clk`. Code 31 therefore divides by 1 and code 0 divides by 32.
- R10: `blank_dly` and `gs_clk_dly` equal `blank` and `gs_clk` as sampled at the previous system clock edge.
- R11: Asserting `blank` during a run darkens all channels. The next release repeats the R3 sequence and restarts the count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gs_clk | input | 1 | Grayscale clock, sampled by `clk` |
| blank | input | 1 | Forces all channels dark when 1 |
| wide_mode | input | 1 | 1 = 16-bit words, 0 = 8-bit words |
| bright_en | input | 1 | Enables the brightness divider |
| bright_code | input | 5 | Brightness code; divide ratio is 32 − code |
| gs_data | input | 256 | Channel words; channel i occupies bits [16i+15:16i] |
| led_on | output | 16 | Per-channel LED enable |
| blank_dly | output | 1 | `blank` delayed by one system clock |
| gs_clk_dly | output | 1 | `gs_clk` delayed by one system clock |

## Verification
A wrong release state shows up in the first cycle after the falling `gs_clk` edge that should have started the run: the whole `led_on` vector is dark there, or lit one grayscale edge too early. A wrong count or prescaler phase moves the moment each channel goes dark. After each grayscale pulse the bench compares all sixteen enables against a count it tracks on its own, so the error is seen within one pulse of the tick that went wrong. A saturation fault shows up as a full-scale channel relighting after the count wraps.

// File: rtl/gspwm_pkg.sv
package gspwm_pkg;

  localparam int GSP_DATA_W   = 16;
  localparam int GSP_NARROW_W = 8;
  localparam int GSP_CODE_W   = 5;
  localparam int GSP_DIV_W    = GSP_CODE_W + 1;

  localparam logic [GSP_DIV_W-1:0] CODE_SPAN = GSP_DIV_W'(1 << GSP_CODE_W);

  typedef enum logic [1:0] {
    SEQ_BLANK     = 2'd0,
    SEQ_WAIT_RISE = 2'd1,
    SEQ_WAIT_FALL = 2'd2,
    SEQ_RUN       = 2'd3
  } seq_state_t;

  // Number of grayscale rises per count tick.
  function automatic logic [GSP_DIV_W-1:0] div_ratio(input logic en,
                                                     input logic [GSP_CODE_W-1:0] code);
    return en ? (CODE_SPAN - {1'b0, code}) : GSP_DIV_W'(1);
  endfunction

  // Saturation value of the brightness count.
  function automatic logic [GSP_DATA_W-1:0] full_scale(input logic wide);
    return wide ? {GSP_DATA_W{1'b1}}
                : {{(GSP_DATA_W-GSP_NARROW_W){1'b0}}, {GSP_NARROW_W{1'b1}}};
  endfunction

  // Effective word of a channel for the selected width.
  function automatic logic [GSP_DATA_W-1:0] word_view(input logic [GSP_DATA_W-1:0] raw,
                                                      input logic wide);
    return wide ? raw : {{(GSP_DATA_W-GSP_NARROW_W){1'b0}}, raw[GSP_NARROW_W-1:0]};
  endfunction

  function automatic logic lit_now(input logic [GSP_DATA_W-1:0] count,
                                   input logic [GSP_DATA_W-1:0] word);
    return count < word;
  endfunction

endpackage

// File: rtl/gspwm_edge_dly.sv
module gspwm_edge_dly (
  input  logic clk,
  input  logic rst_n,
  input  logic gs_clk,
  input  logic blank,
  output logic gs_clk_dly,
  output logic blank_dly,
  output logic gs_rise,
  output logic gs_fall
);

  logic primed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gs_clk_dly <= 1'b0;
      blank_dly  <= 1'b0;
      primed     <= 1'b0;
    end else begin
      gs_clk_dly <= gs_clk;
      blank_dly  <= blank;
      primed     <= 1'b1;
    end
  end

  assign gs_rise = gs_clk & ~gs_clk_dly;
  assign gs_fall = ~gs_clk & gs_clk_dly;

  // R10
  blank_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> (blank_dly == $past(blank)));

  // R10
  gs_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> (gs_clk_dly == $past(gs_clk)));

endmodule

// File: rtl/gspwm_release_seq.sv
module gspwm_release_seq
  import gspwm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic blank,
  input  logic gs_rise,
  input  logic gs_fall,
  output logic run,
  output logic start
);

  seq_state_t state, state_nx;

  always_comb begin
    state_nx = state;
    if (blank) begin
      state_nx = SEQ_BLANK;
    end else begin
      unique case (state)
        SEQ_BLANK:     state_nx = SEQ_WAIT_RISE;
        SEQ_WAIT_RISE: if (gs_rise) state_nx = SEQ_WAIT_FALL;
        SEQ_WAIT_FALL: if (gs_fall) state_nx = SEQ_RUN;
        SEQ_RUN:       state_nx = SEQ_RUN;
        default:       state_nx = SEQ_BLANK;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEQ_BLANK;
    else        state <= state_nx;
  end

  assign run   = (state == SEQ_RUN);
  assign start = (state == SEQ_WAIT_FALL) & gs_fall & ~blank;

  // R3
  rel_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> ($past(state) == SEQ_WAIT_FALL));

  // R2
  blank_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blank |=> !run);

endmodule

// File: rtl/gspwm_prescale.sv
module gspwm_prescale
  import gspwm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 start,
  input  logic                 gs_rise,
  input  logic [GSP_DIV_W-1:0] div,
  output logic                 tick
);

  logic [GSP_DIV_W-1:0] pre_cnt;
  logic                 at_last;

  assign at_last = (pre_cnt >= (div - GSP_DIV_W'(1)));
  assign tick    = run & gs_rise & at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
    end else if (start || !run) begin
      pre_cnt <= '0;
    end else if (gs_rise) begin
      pre_cnt <= at_last ? '0 : pre_cnt + GSP_DIV_W'(1);
    end
  end

  // R8
  unity_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && gs_rise && div == GSP_DIV_W'(1)) |-> tick);

  // R9
  tick_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (gs_rise && run));

endmodule

// File: rtl/gspwm_counter.sv
module gspwm_counter
  import gspwm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  tick,
  input  logic                  wide,
  output logic [GSP_DATA_W-1:0] count
);

  logic at_full;

  assign at_full = (count >= full_scale(wide));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (start) begin
      count <= '0;
    end else if (tick && !at_full) begin
      count <= count + GSP_DATA_W'(1);
    end
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !start && at_full) |=> $stable(count));

  // R4
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !start && !at_full) |=> (count == $past(count) + GSP_DATA_W'(1)));

endmodule

// File: rtl/gspwm_channels.sv
module gspwm_channels
  import gspwm_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         run,
  input  logic                         blank,
  input  logic                         wide,
  input  logic [GSP_DATA_W-1:0]        count,
  input  logic [NUM_CH*GSP_DATA_W-1:0] data,
  output logic [NUM_CH-1:0]            lit
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [GSP_DATA_W-1:0] word;
    assign word   = word_view(data[i*GSP_DATA_W +: GSP_DATA_W], wide);
    assign lit[i] = run & ~blank & lit_now(count, word);

    // R5
    zero_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word == '0) |-> !lit[i]);
  end

endmodule

// File: rtl/gspwm_top.sv
module gspwm_top
  import gspwm_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         gs_clk,
  input  logic                         blank,
  input  logic                         wide_mode,
  input  logic                         bright_en,
  input  logic [GSP_CODE_W-1:0]        bright_code,
  input  logic [NUM_CH*GSP_DATA_W-1:0] gs_data,
  output logic [NUM_CH-1:0]            led_on,
  output logic                         blank_dly,
  output logic                         gs_clk_dly
);

  logic                  gs_rise_w, gs_fall_w;
  logic                  run_w, start_w, tick_w;
  logic [GSP_DIV_W-1:0]  div_w;
  logic [GSP_DATA_W-1:0] count_w;

  assign div_w = div_ratio(bright_en, bright_code);

  gspwm_edge_dly u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .gs_clk     (gs_clk),
    .blank      (blank),
    .gs_clk_dly (gs_clk_dly),
    .blank_dly  (blank_dly),
    .gs_rise    (gs_rise_w),
    .gs_fall    (gs_fall_w)
  );

  gspwm_release_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .blank   (blank),
    .gs_rise (gs_rise_w),
    .gs_fall (gs_fall_w),
    .run     (run_w),
    .start   (start_w)
  );

  gspwm_prescale u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_w),
    .start   (start_w),
    .gs_rise (gs_rise_w),
    .div     (div_w),
    .tick    (tick_w)
  );

  gspwm_counter u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start_w),
    .tick  (tick_w),
    .wide  (wide_mode),
    .count (count_w)
  );

  gspwm_channels #(.NUM_CH(NUM_CH)) u_ch (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_w),
    .blank (blank),
    .wide  (wide_mode),
    .count (count_w),
    .data  (gs_data),
    .lit   (led_on)
  );

  // R2
  blank_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> (led_on == '0));

  // R4 / R11
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_w) |-> (count_w == '0));

endmodule

// File: tb/sim_gspwm_top.sv
module sim_gspwm_top;

  localparam int NCH = 16;
  localparam int DW  = 16;
  localparam int NV  = 7;
  // [31] wide, [30] bright_en, [29:25] code, [24:16] pulses, [15:0] seed
  localparam logic [31:0] VEC [NV] = '{
    {1'b0, 1'b0, 5'd3,  9'd40,  16'd7},
    {1'b0, 1'b1, 5'd31, 9'd30,  16'd3},
    {1'b0, 1'b1, 5'd29, 9'd30,  16'd5},
    {1'b1, 1'b1, 5'd28, 9'd40,  16'd9},
    {1'b0, 1'b1, 5'd0,  9'd70,  16'd2},
    {1'b0, 1'b0, 5'd0,  9'd260, 16'd1},
    {1'b1, 1'b0, 5'd0,  9'd50,  16'd11}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gs_clk = 1'b0, blank = 1'b0, wide_mode = 1'b0, bright_en = 1'b0;
  logic [4:0] bright_code = '0;
  logic [NCH*DW-1:0] gs_data = '0;
  logic [NCH-1:0] led_on;
  logic blank_dly, gs_clk_dly;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [DW-1:0] chan [NCH];

  always #2 clk = ~clk;

  gspwm_top #(.NUM_CH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .gs_clk(gs_clk), .blank(blank),
    .wide_mode(wide_mode), .bright_en(bright_en), .bright_code(bright_code),
    .gs_data(gs_data), .led_on(led_on), .blank_dly(blank_dly), .gs_clk_dly(gs_clk_dly)
  );

  function automatic int m_div(input logic en, input logic [4:0] code);
    if (!en) return 1;
    return 32 - int'(code);
  endfunction

  function automatic logic [NCH-1:0] m_leds(input int cnt, input logic wide);
    logic [NCH-1:0] e;
    for (int i = 0; i < NCH; i++) begin
      int w;
      w = wide ? int'(chan[i]) : int'(chan[i][7:0]);
      e[i] = (cnt < w);
    end
    return e;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic load_data(input int seed);
    for (int i = 0; i < NCH; i++) chan[i] = DW'((seed * i * 13 + i) % 45);
    chan[0]  = 16'h0000;
    chan[13] = 16'h0100;
    chan[14] = 16'h00FF;
    chan[15] = 16'hAB05;
    for (int i = 0; i < NCH; i++) gs_data[i*DW +: DW] = chan[i];
  endtask

  task automatic gs_pulse();
    gs_clk = 1'b1;
    @(negedge clk); @(negedge clk);
    gs_clk = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  // blank pulse, then release through rise and fall; checks R2 and R3
  task automatic blank_release();
    blank = 1'b1;
    #1 chk("R2 blank dark", 32'(led_on), 32'd0);
    @(negedge clk);
    chk("R2 blank held", 32'(led_on), 32'd0);
    blank = 1'b0;
    @(negedge clk);
    chk("R3 dark before rise", 32'(led_on), 32'd0);
    gs_clk = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R3 dark after rise", 32'(led_on), 32'd0);
    gs_clk = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    load_data(1);
    repeat (3) @(negedge clk);
    chk("R1 reset leds", 32'(led_on), 32'd0);
    chk("R1 reset dly", {30'd0, blank_dly, gs_clk_dly}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", 32'(led_on), 32'd0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic wd, en; logic [4:0] cd; int np, dv, fs, cnt;
      string tag;
      wd = VEC[v][31]; en = VEC[v][30]; cd = VEC[v][29:25];
      np = int'(VEC[v][24:16]);
      wide_mode = wd; bright_en = en; bright_code = cd;
      load_data(int'(VEC[v][15:0]));
      dv = m_div(en, cd);
      fs = wd ? 65535 : 255;
      if (en)        tag = "R9 divided count";
      else if (wd)   tag = "R7 wide count";
      else if (np > 256) tag = "R6 narrow saturation";
      else           tag = "R8 unity divide";
      blank_release();
      chk("R4 lit at release", 32'(led_on), 32'(m_leds(0, wd)));
      chk("R5 zero word dark", 32'(led_on[0]), 32'd0);
      for (int p = 1; p <= np; p++) begin
        gs_pulse();
        cnt = p / dv;
        if (cnt > fs) cnt = fs;
        chk(tag, 32'(led_on), 32'(m_leds(cnt, wd)));
      end
    end

    // R11: blank in mid-run restarts the count
    wide_mode = 1'b0; bright_en = 1'b0; bright_code = '0;
    load_data(4);
    blank_release();
    for (int p = 0; p < 6; p++) gs_pulse();
    chk("R4 mid run", 32'(led_on), 32'(m_leds(6, 1'b0)));
    blank_release();
    chk("R11 restart at zero", 32'(led_on), 32'(m_leds(0, 1'b0)));

    // R10: delayed copies
    @(negedge clk);
    blank = 1'b1; gs_clk = 1'b1;
    #1 chk("R10 dly before edge", {30'd0, blank_dly, gs_clk_dly}, 32'd0);
    @(negedge clk);
    chk("R10 dly after edge", {30'd0, blank_dly, gs_clk_dly}, 32'd3);
    blank = 1'b0;
    @(negedge clk);
    chk("R10 blank dly drop", {30'd0, blank_dly, gs_clk_dly}, 32'd1);
    gs_clk = 1'b0;
    @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule